// File: doc/BRIEF.md
# Card Clock and Soft-Reset Controller

This block produces the clock that drives a memory card bus and carries out the clock start, clock stop and soft-reset commands. Software sends commands through a one-word control write port. Each command is a one-shot strobe bit in that word. A separate write port loads a 3-bit divider exponent. Software reads two status flags and polls them until they settle: one says the card clock is running and the other says a soft reset is in progress. A one-cycle start-operation pulse tells the command engine to begin a command.

The system clock `clk_i` runs at twice the fixed card reference rate, for example 48 MHz for a 24 MHz reference. With that clock the card clock can be a plain register output and still cover every ratio from the reference rate itself (exponent 0) down to one 128th of it (exponent 7). In `clk_i` cycles the card clock period is 2^(d+1). Its high and low phases are each 2^d cycles long, where d is the active exponent. The clock stops only in its low phase and the exponent changes only at a period boundary, so the card never sees a shortened pulse from either action.

Top module: `cardclk_ctrl`

## Requirements
- R1: After `rst_ni` is released, `card_clk_o`, `clk_running_o`, `resetting_o` and `op_start_o` are all 0.
- R2: A control write with the start bit (bit 1) set starts a stopped clock. `clk_running_o` reads 1 in the cycle after the write. The clock then spends a full low phase of 2^d cycles before its first rising edge.
- R3: While the clock runs with exponent d, each high phase and each low phase of `card_clk_o` lasts exactly 2^d `clk_i` cycles, for d from 0 to 7. `card_clk_o` changes only while the clock is running.
- R4: A control write with the stop bit (bit 0) set stops the clock. If `card_clk_o` is low, `clk_running_o` drops in the next cycle and the clock stays low. If `card_clk_o` is high, the high phase completes its full 2^d cycles and `clk_running_o` drops on the same edge that takes the clock low. A stopped clock is always low.
- R5: A control write with the start-operation bit (bit 2) set produces a one-cycle `op_start_o` pulse in the cycle after the write, provided the clock is running or the same write sets the start bit. When the write carries both bits, `op_start_o` and `clk_running_o` rise together.
- R6: A start-operation request produces no pulse if the clock is stopped and the start bit is clear, or if the same write sets the stop bit.
- R7: A divider write while the clock runs leaves the current period unchanged. The new exponent takes effect from the next falling edge of `card_clk_o`.
- R8: A divider write while the clock is stopped is applied at the next clock start.
- R9: A control write with the reset bit (bit 3) set forces the clock low and stopped in the next cycle. `resetting_o` then stays at 1 for exactly 16 cycles and clears by itself.
- R10: When a soft reset completes, the clock is stopped and the divider exponent is 0.
- R11: While `resetting_o` is 1, control writes and divider writes are ignored. A write that sets the reset bit ignores the other bits of that write.
- R12: A start bit written while the clock already runs is ignored. The running phase is not restarted.
- R13: When a write sets both the start and stop bits, the stop bit wins. A stopped clock stays stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, twice the card reference rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 4 | Control word: bit 0 stop, bit 1 start, bit 2 start operation, bit 3 soft reset |
| div_we_i | input | 1 | Divider write strobe |
| div_wdata_i | input | 3 | Divider exponent d (card clock = reference / 2^d) |
| card_clk_o | output | 1 | Divided card bus clock |
| clk_running_o | output | 1 | Status: card clock running |
| resetting_o | output | 1 | Status: soft reset in progress |
| op_start_o | output | 1 | One-cycle pulse to the command engine |

## Verification
The bench builds the block with its defaults: a 3-bit exponent and a 16-cycle soft reset. The exponent covers 0, 1, 2, 3, 5 and 7, so the bench measures the shortest phase of one cycle, the longest of 128 cycles, and a change from 2-cycle to 8-cycle phases across a boundary. The stop timing is checked once from the low phase and once from the middle of a high phase. The 16-cycle reset length is short enough for the bench to count a soft reset cycle by cycle while writes are issued into it.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

  typedef struct packed {
    logic srst;
    logic op;
    logic start;
    logic stop;
  } ctrl_cmd_t;

  // Bit positions of the control word are decoded here only.
  function automatic ctrl_cmd_t decode_ctrl(logic [3:0] w);
    ctrl_cmd_t c;
    c.stop  = w[0];
    c.start = w[1];
    c.op    = w[2];
    c.srst  = w[3];
    return c;
  endfunction

  // Length of one card clock phase in system cycles for exponent d.
  function automatic logic [31:0] phase_len(logic [31:0] d);
    return 32'd1 << d;
  endfunction

endpackage

// File: rtl/cardclk_decode.sv
module cardclk_decode
  import cardclk_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [3:0]       ctrl_wdata,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             resetting,
  input  logic             rst_done,
  input  logic             running,
  output logic             soft_start,
  output logic             start_cmd,
  output logic             stop_cmd,
  output logic             op_pulse,
  output logic [DIV_W-1:0] div_req
);

  ctrl_cmd_t cmd;
  logic      cmd_ok;

  always_comb begin
    cmd        = decode_ctrl(ctrl_wdata);
    soft_start = ctrl_we && cmd.srst && !resetting;
    cmd_ok     = ctrl_we && !cmd.srst && !resetting;
    start_cmd  = cmd_ok && cmd.start;
    stop_cmd   = cmd_ok && cmd.stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_pulse <= 1'b0;
      div_req  <= '0;
    end else begin
      op_pulse <= cmd_ok && cmd.op && !cmd.stop && (running || cmd.start);
      if (rst_done)
        div_req <= '0;
      else if (div_we && !resetting)
        div_req <= div_wdata;
    end
  end

endmodule

// File: rtl/cardclk_rstseq.sv
module cardclk_rstseq #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_start,
  output logic resetting,
  output logic rst_done
);

  localparam int RC_W = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
  localparam logic [RC_W-1:0] LAST = RC_W'(RST_CYCLES - 1);

  logic [RC_W-1:0] cnt;

  assign rst_done = resetting && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resetting <= 1'b0;
      cnt       <= '0;
    end else if (soft_start) begin
      resetting <= 1'b1;
      cnt       <= '0;
    end else if (resetting) begin
      if (rst_done) begin
        resetting <= 1'b0;
        cnt       <= '0;
      end else begin
        cnt <= cnt + RC_W'(1);
      end
    end
  end

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import cardclk_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic [DIV_W-1:0] div_req,
  output logic             card_clk,
  output logic             running,
  output logic [DIV_W-1:0] div_act,
  output logic             fall_evt
);

  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;
  logic             stop_pend;
  logic             wrap;

  always_comb begin
    last_cnt = CNT_W'(phase_len(32'(div_act)) - 32'd1);
    wrap     = running && (cnt == last_cnt);
    fall_evt = wrap && card_clk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      stop_pend <= 1'b0;
      cnt       <= '0;
      card_clk  <= 1'b0;
      div_act   <= '0;
    end else if (kill) begin
      running   <= 1'b0;
      stop_pend <= 1'b0;
      cnt       <= '0;
      card_clk  <= 1'b0;
      div_act   <= '0;
    end else if (!running) begin
      div_act <= div_req;
      cnt     <= '0;
      if (start_cmd && !stop_cmd)
        running <= 1'b1;
    end else if (stop_cmd && !card_clk) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (wrap) begin
      cnt      <= '0;
      card_clk <= ~card_clk;
      if (card_clk) begin
        div_act <= div_req;
        if (stop_cmd || stop_pend) begin
          running   <= 1'b0;
          stop_pend <= 1'b0;
        end
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (stop_cmd)
        stop_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl #(
  parameter int DIV_W      = 3,
  parameter int RST_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [3:0]       ctrl_wdata_i,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  output logic             card_clk_o,
  output logic             clk_running_o,
  output logic             resetting_o,
  output logic             op_start_o
);

  logic             soft_start;
  logic             start_cmd;
  logic             stop_cmd;
  logic             rst_done;
  logic             kill;
  logic [DIV_W-1:0] div_req;
  logic [DIV_W-1:0] div_act_w;
  logic             fall_evt_w;

  assign kill = soft_start || resetting_o;

  cardclk_decode #(.DIV_W(DIV_W)) u_decode (
    .clk        (clk_i),
    .rst_n      (rst_ni),
    .ctrl_we    (ctrl_we_i),
    .ctrl_wdata (ctrl_wdata_i),
    .div_we     (div_we_i),
    .div_wdata  (div_wdata_i),
    .resetting  (resetting_o),
    .rst_done   (rst_done),
    .running    (clk_running_o),
    .soft_start (soft_start),
    .start_cmd  (start_cmd),
    .stop_cmd   (stop_cmd),
    .op_pulse   (op_start_o),
    .div_req    (div_req)
  );

  cardclk_rstseq #(.RST_CYCLES(RST_CYCLES)) u_rstseq (
    .clk        (clk_i),
    .rst_n      (rst_ni),
    .soft_start (soft_start),
    .resetting  (resetting_o),
    .rst_done   (rst_done)
  );

  cardclk_gen #(.DIV_W(DIV_W)) u_gen (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .kill      (kill),
    .start_cmd (start_cmd),
    .stop_cmd  (stop_cmd),
    .div_req   (div_req),
    .card_clk  (card_clk_o),
    .running   (clk_running_o),
    .div_act   (div_act_w),
    .fall_evt  (fall_evt_w)
  );

endmodule

// File: rtl/cardclk_ctrl_chk.sv
module cardclk_ctrl_chk #(
  parameter int DIV_W      = 3,
  parameter int RST_CYCLES = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             card_clk_o,
  input logic             clk_running_o,
  input logic             resetting_o,
  input logic             op_start_o,
  input logic [DIV_W-1:0] div_act_w,
  input logic             fall_evt_w
);

  localparam int RW = $clog2(RST_CYCLES + 2);

  logic [RW-1:0] rs_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      rs_cnt <= '0;
    else if (resetting_o)
      rs_cnt <= rs_cnt + RW'(1);
    else
      rs_cnt <= '0;
  end

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_running_o |-> !card_clk_o); // R4

  AST_TOGGLE_WHEN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_clk_o != $past(card_clk_o)) |-> $past(clk_running_o)); // R3

  AST_HIGH_STOP_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(clk_running_o) && !resetting_o && $past(card_clk_o)) |-> $past(fall_evt_w)); // R4

  AST_OP_WITH_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> clk_running_o); // R5

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resetting_o |-> (!clk_running_o && !op_start_o && !card_clk_o)); // R9

  AST_RESET_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(resetting_o) |-> (rs_cnt == RW'(RST_CYCLES))); // R9

  AST_RESET_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_cnt <= RW'(RST_CYCLES)); // R9

  AST_DIV_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_running_o && $past(clk_running_o) && (div_act_w != $past(div_act_w)))
      |-> $past(fall_evt_w)); // R7

  AST_RESET_DIV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(resetting_o) |=> (div_act_w == '0)); // R10

endmodule

bind cardclk_ctrl cardclk_ctrl_chk #(.DIV_W(DIV_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .card_clk_o    (card_clk_o),
  .clk_running_o (clk_running_o),
  .resetting_o   (resetting_o),
  .op_start_o    (op_start_o),
  .div_act_w     (div_act_w),
  .fall_evt_w    (fall_evt_w)
);

// File: tb/cardclk_ctrl_bench.sv
module cardclk_ctrl_bench;

  localparam int DIV_W = 3;
  localparam int RSTC  = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ctrl_we_i = 1'b0;
  logic [3:0]       ctrl_wdata_i = '0;
  logic             div_we_i = 1'b0;
  logic [DIV_W-1:0] div_wdata_i = '0;
  logic             card_clk_o;
  logic             clk_running_o;
  logic             resetting_o;
  logic             op_start_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  cardclk_ctrl #(.DIV_W(DIV_W), .RST_CYCLES(RSTC)) u_cardclk_ctrl (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .div_we_i, .div_wdata_i,
    .card_clk_o, .clk_running_o, .resetting_o, .op_start_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge.
  task automatic wr_ctrl(input logic [3:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(posedge clk_i); @(negedge clk_i);
    ctrl_we_i = 1'b0; ctrl_wdata_i = '0;
  endtask

  task automatic wr_div(input int d);
    div_we_i = 1'b1; div_wdata_i = DIV_W'(d);
    @(posedge clk_i); @(negedge clk_i);
    div_we_i = 1'b0; div_wdata_i = '0;
  endtask

  task automatic count_lvl(input logic lvl, output int n);
    n = 0;
    while (card_clk_o == lvl && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic wait_high();
    for (int i = 0; i < 1000 && card_clk_o == 1'b0; i++) @(negedge clk_i);
  endtask

  task automatic halt_clock();
    wr_ctrl(4'b0001);
    for (int i = 0; i < 1000 && clk_running_o; i++) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset_state();
    chk("R1 card_clk", card_clk_o, 0);
    chk("R1 running", clk_running_o, 0);
    chk("R1 resetting", resetting_o, 0);
    chk("R1 op_start", op_start_o, 0);
  endtask

  task automatic t_freq(input int d);
    int n;
    int ph;
    ph = 1 << d;
    wr_div(d);
    wr_ctrl(4'b0010);
    chk("R2 running after start", clk_running_o, 1);
    chk("R2 clock low after start", card_clk_o, 0);
    count_lvl(1'b0, n); chk("R2 first low phase / R8 divider applied at start", n, ph);
    count_lvl(1'b1, n); chk("R3 high phase", n, ph);
    count_lvl(1'b0, n); chk("R3 low phase", n, ph);
    halt_clock();
  endtask

  task automatic t_stop_low();
    wr_div(2);
    wr_ctrl(4'b0010);
    wr_ctrl(4'b0001);
    chk("R4 stop in low phase: running", clk_running_o, 0);
    chk("R4 stop in low phase: clock", card_clk_o, 0);
    repeat (10) @(negedge clk_i);
    chk("R4 stays low after stop", card_clk_o, 0);
  endtask

  task automatic t_stop_high();
    int n;
    wr_div(2);
    wr_ctrl(4'b0010);
    wait_high();
    wr_ctrl(4'b0001);
    chk("R4 running kept during high phase", clk_running_o, 1);
    count_lvl(1'b1, n);
    chk("R4 full high phase before stop", n + 1, 4);
    chk("R4 running drops with falling edge", clk_running_o, 0);
    @(negedge clk_i);
  endtask

  task automatic t_op();
    wr_ctrl(4'b0100);
    chk("R6 op with clock stopped", op_start_o, 0);
    wr_ctrl(4'b0110);
    chk("R5 op with start: pulse", op_start_o, 1);
    chk("R5 op with start: running", clk_running_o, 1);
    @(negedge clk_i);
    chk("R5 pulse lasts one cycle", op_start_o, 0);
    wr_ctrl(4'b0100);
    chk("R5 op while running", op_start_o, 1);
    wr_ctrl(4'b0101);
    chk("R6 op with stop", op_start_o, 0);
    for (int i = 0; i < 1000 && clk_running_o; i++) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_restart_ignored();
    int n;
    wr_div(2);
    wr_ctrl(4'b0010);
    wait_high();
    wr_ctrl(4'b0010);
    count_lvl(1'b1, n);
    chk("R12 high phase not restarted", n + 1, 4);
    count_lvl(1'b0, n);
    chk("R12 following low phase", n, 4);
    halt_clock();
  endtask

  task automatic t_start_stop();
    wr_ctrl(4'b0011);
    chk("R13 start+stop stays stopped", clk_running_o, 0);
    repeat (5) @(negedge clk_i);
    chk("R13 clock still low", card_clk_o, 0);
  endtask

  task automatic t_div_change();
    int n;
    wr_div(1);
    wr_ctrl(4'b0010);
    wait_high();
    wr_div(3);
    count_lvl(1'b1, n);
    chk("R7 current high phase keeps old divider", n + 1, 2);
    count_lvl(1'b0, n);
    chk("R7 new divider from next falling edge (low)", n, 8);
    count_lvl(1'b1, n);
    chk("R7 new divider (high)", n, 8);
    halt_clock();
  endtask

  task automatic t_soft_reset();
    int n;
    wr_div(5);
    wr_ctrl(4'b0010);
    repeat (3) @(negedge clk_i);
    wr_ctrl(4'b1110);
    chk("R9 resetting set", resetting_o, 1);
    chk("R9 running cleared", clk_running_o, 0);
    chk("R9 clock low", card_clk_o, 0);
    chk("R11 op ignored with reset bit", op_start_o, 0);
    n = 1;
    wr_ctrl(4'b0010);
    if (resetting_o) n++;
    wr_div(6);
    if (resetting_o) n++;
    while (resetting_o && n < 100) begin
      @(negedge clk_i);
      if (resetting_o) n++;
    end
    chk("R9 reset length", n, RSTC);
    chk("R11 start during reset ignored", clk_running_o, 0);
    chk("R10 clock stopped after reset", card_clk_o, 0);
    wr_ctrl(4'b0010);
    count_lvl(1'b0, n);
    chk("R10/R11 divider zero after reset (low)", n, 1);
    count_lvl(1'b1, n);
    chk("R10/R11 divider zero after reset (high)", n, 1);
    halt_clock();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_state();
    t_freq(0);
    t_freq(3);
    t_freq(7);
    t_stop_low();
    t_stop_high();
    t_op();
    t_restart_ignored();
    t_start_stop();
    t_div_change();
    t_soft_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule